// File: doc/BRIEF.md
# Zero-odd one-even sequence recognizer

This block watches a serial stream of single bits and raises its output whenever the
stream seen since reset holds an odd number of 0s and an even, nonzero number of 1s.
A bit is taken only on a clock edge where its valid strobe is high. On all other edges
the machine holds its state.

The design is a Moore machine with six states. Each state pairs the parity of the 0
count with one of three classes for the 1 count: none yet, odd, or even and nonzero.
The output is held in a register and depends on the state alone. The current state
index is brought out for debug. A parameter selects one-hot or binary storage of the
state. Both choices behave the same at the ports.

Top module: `zo_recog`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with no valid bit, `state_idx_o` is 0 and `match_o` is 0.
- R2: On an edge where `bit_valid` is low, `state_idx_o` and `match_o` keep their values, whatever `bit_in` is.
- R3: A valid 0 flips the zero-parity bit (`state_idx_o[0]`, 1 = odd) and leaves the ones class (`state_idx_o[2:1]`) unchanged.
- R4: A valid 1 leaves `state_idx_o[0]` unchanged. It moves the ones class from none (0) or even-nonzero (2) to odd (1), and from odd (1) to even-nonzero (2).
- R5: `match_o` is 1 exactly when the number of valid 0s since reset is odd and the number of valid 1s is even and greater than zero. This is state index 5.
- R6: `state_idx_o` equals 2 × ones class + zero parity, so it never leaves the range 0 to 5.
- R7: A bit sampled on edge N shows in both `state_idx_o` and `match_o` right after edge N, in the same cycle.
- R8: With `ONE_HOT` set to 0 or to 1, the block gives identical `state_idx_o` and `match_o` for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | High when `bit_in` is to be sampled on this edge |
| bit_in | input | 1 | Serial data bit |
| match_o | output | 1 | Registered recognition flag |
| state_idx_o | output | 3 | Current state index, for debug |

## Verification
Every result is due one rising edge after its stimulus. The state register and the
output register load on the same edge that samples a valid bit. For that reason the
bench drives inputs at the falling edge and compares both outputs 1 ns after the next
rising edge, against counts of 0s and 1s kept in the bench. Hold cycles use the same
timing and check that both outputs are unchanged. A second instance with binary state
storage is compared against the expected values on every check.

// File: rtl/zo_recog_pkg.sv
package zo_recog_pkg;
    localparam int NUM_STATES = 6;
    localparam int IDX_W      = $clog2(NUM_STATES);
    localparam int CLS_W      = 2;

    // Class of the ones count; forms the upper bits of the state index.
    typedef enum logic [CLS_W-1:0] {
        ONES_NONE = 2'd0,
        ONES_ODD  = 2'd1,
        ONES_EVEN = 2'd2
    } ones_cls_e;

    localparam logic [IDX_W-1:0] RESET_IDX  = '0;
    localparam logic [IDX_W-1:0] ACCEPT_IDX = {ONES_EVEN, 1'b1};

    typedef struct packed {
        ones_cls_e cls;
        logic      zpar;
    } rec_state_t;

    function automatic rec_state_t idx_split(input logic [IDX_W-1:0] idx);
        rec_state_t s;
        s.cls  = ones_cls_e'(idx[IDX_W-1:1]);
        s.zpar = idx[0];
        return s;
    endfunction
endpackage

// File: rtl/zo_step.sv
module zo_step
    import zo_recog_pkg::*;
(
    input  logic [IDX_W-1:0] cur_idx_i,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [IDX_W-1:0] nxt_idx_o
);
    rec_state_t cur_s;
    rec_state_t nxt_s;

    always_comb begin
        cur_s = idx_split(cur_idx_i);
        nxt_s = cur_s;
        if (bit_valid) begin
            if (bit_in) begin
                // A one alternates the ones count between odd and even-nonzero.
                nxt_s.cls = (cur_s.cls == ONES_ODD) ? ONES_EVEN : ONES_ODD;
            end else begin
                nxt_s.zpar = ~cur_s.zpar;
            end
        end
        nxt_idx_o = {nxt_s.cls, nxt_s.zpar};
    end
endmodule

// File: rtl/zo_state_reg.sv
module zo_state_reg
    import zo_recog_pkg::*;
#(
    parameter bit ONE_HOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] nxt_idx_i,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             match_o
);
    localparam int ENC_W = ONE_HOT ? NUM_STATES : IDX_W;
    localparam logic [ENC_W-1:0] ENC_RST = ENC_W'(ONE_HOT ? 1 : 0);

    typedef struct packed {
        logic [ENC_W-1:0] enc;
        logic             hit;
    } reg_t;

    reg_t             r_d;
    reg_t             r_q;
    logic [ENC_W-1:0] enc_nxt;
    logic [IDX_W-1:0] idx_cur;

    generate
        if (ONE_HOT) begin : g_onehot
            always_comb begin
                enc_nxt = '0;
                for (int k = 0; k < NUM_STATES; k++) begin
                    if (nxt_idx_i == IDX_W'(k)) enc_nxt[k] = 1'b1;
                end
            end
            always_comb begin
                idx_cur = '0;
                for (int k = 0; k < NUM_STATES; k++) begin
                    if (r_q.enc[k]) idx_cur = idx_cur | IDX_W'(k);
                end
            end
        end else begin : g_binary
            assign enc_nxt = nxt_idx_i;
            assign idx_cur = r_q.enc;
        end
    endgenerate

    always_comb begin
        r_d.enc = enc_nxt;
        r_d.hit = (nxt_idx_i == ACCEPT_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.enc <= ENC_RST;
            r_q.hit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_idx_o = idx_cur;
    assign match_o   = r_q.hit;
endmodule

// File: rtl/zo_recog.sv
module zo_recog
    import zo_recog_pkg::*;
#(
    parameter bit ONE_HOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             match_o,
    output logic [IDX_W-1:0] state_idx_o
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;

    zo_step u_step (
        .cur_idx_i (idx_q),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .nxt_idx_o (idx_d)
    );

    zo_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_idx_i (idx_d),
        .cur_idx_o (idx_q),
        .match_o   (match_o)
    );

    assign state_idx_o = idx_q;
endmodule

// File: rtl/zo_recog_chk.sv
module zo_recog_chk
    import zo_recog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             bit_in,
    input logic             match_o,
    input logic [IDX_W-1:0] state_idx_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (state_idx_o == RESET_IDX) && !match_o);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(state_idx_o) && $stable(match_o));

    // R3
    zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && !bit_in |=> (state_idx_o[0] != $past(state_idx_o[0]))
                              && (state_idx_o[2:1] == $past(state_idx_o[2:1])));

    // R4
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && bit_in |=> (state_idx_o[0] == $past(state_idx_o[0]))
            && (state_idx_o[2:1] == (($past(state_idx_o[2:1]) == 2'd1) ? 2'd2 : 2'd1)));

    // R5
    match_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o == (state_idx_o == 3'd5));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_idx_o <= 3'd5);
endmodule

bind zo_recog zo_recog_chk u_chk (.*);

// File: tb/test_zo_recog.sv
module test_zo_recog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       match_oh, match_bn;
    logic [2:0] idx_oh, idx_bn;

    int checks = 0;
    int fails  = 0;
    int zeros  = 0;
    int ones   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    zo_recog #(.ONE_HOT(1'b1)) i_zo_recog (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .match_o(match_oh), .state_idx_o(idx_oh));

    zo_recog #(.ONE_HOT(1'b0)) i_zo_recog_bin (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .match_o(match_bn), .state_idx_o(idx_bn));

    function automatic logic [2:0] exp_idx();
        int cls = (ones == 0) ? 0 : ((ones % 2 == 1) ? 1 : 2);
        return 3'(cls * 2 + (zeros % 2));
    endfunction

    function automatic logic exp_match();
        return (zeros % 2 == 1) && (ones % 2 == 0) && (ones > 0);
    endfunction

    task automatic chk(input string req, input logic [2:0] act_i, input logic act_m,
                       input logic [2:0] exp_i, input logic exp_m);
        checks++;
        if (act_i !== exp_i || act_m !== exp_m) begin
            fails++;
            $display("FAIL %s: idx=%0d match=%0b expected idx=%0d match=%0b",
                     req, act_i, act_m, exp_i, exp_m);
        end
    endtask

    // Compare both instances with the software counts (R5, R6, R8).
    task automatic chk_both(input string req);
        chk({req, " one-hot"}, idx_oh, match_oh, exp_idx(), exp_match());
        chk({req, " binary R8"}, idx_bn, match_bn, exp_idx(), exp_match());
    endtask

    // Drive at falling edge, check 1 ns after the sampling rising edge (R7).
    task automatic send(input logic v, input logic b, input string req);
        @(negedge clk);
        bit_valid = v;
        bit_in    = b;
        @(posedge clk);
        #1;
        if (v) begin
            if (b) ones++;
            else zeros++;
        end
        chk_both(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        zeros = 0;
        ones  = 0;
        #1;
        chk_both("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_both("R1 after reset");
    endtask

    task automatic t_zero_parity();
        do_reset();
        for (int k = 0; k < 4; k++) send(1'b1, 1'b0, "R3 zero flips parity");
    endtask

    task automatic t_ones_class();
        do_reset();
        send(1'b1, 1'b1, "R4 none to odd");
        send(1'b1, 1'b1, "R4 odd to even");
        send(1'b1, 1'b1, "R4 even to odd");
        send(1'b1, 1'b1, "R4 odd to even again");
    endtask

    task automatic t_accept_path();
        do_reset();
        send(1'b1, 1'b0, "R5 one zero no ones");
        send(1'b1, 1'b1, "R5 odd ones no match");
        send(1'b1, 1'b1, "R5 match on even ones odd zeros R7");
        send(1'b1, 1'b0, "R5 leave match on zero");
        send(1'b1, 1'b0, "R5 back to match");
        send(1'b1, 1'b1, "R5 leave match on one");
    endtask

    task automatic t_hold();
        do_reset();
        send(1'b1, 1'b0, "R2 setup");
        send(1'b1, 1'b1, "R2 setup");
        send(1'b1, 1'b1, "R2 setup into match");
        for (int k = 0; k < 6; k++) send(1'b0, k[0], "R2 hold while invalid");
    endtask

    task automatic t_random();
        for (int s = 0; s < 8; s++) begin
            do_reset();
            for (int k = 0; k < 400; k++) begin
                send(($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                     "R5 R6 random stream");
            end
        end
    endtask

    task automatic t_midstream_reset();
        send(1'b1, 1'b1, "R1 pre");
        do_reset();
        send(1'b1, 1'b1, "R1 restart counts");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        t_zero_parity();
        t_ones_class();
        t_accept_path();
        t_hold();
        t_random();
        t_midstream_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule